// File: doc/BRIEF.md
# Dual-Rail Ripple Adder with Early Carry Completion

This block adds two W-bit operands and a carry-in. Every operand bit, carry and sum bit is carried as a pair of wires, a true rail and a false rail, so the data itself shows whether a value has arrived. The adder sits on a four-phase return-to-zero channel between two latches and must leave that handshake intact. A set of input codes all becoming valid starts a computation. The inputs all returning to empty starts the reset phase.

The design is a clocked emulation. Each bit slice holds its carry in a register, and carry information moves one slice per clock. A slice whose two operand bits agree settles its carry as soon as those operand bits arrive, without waiting for the carry from below. Only runs of slices with differing operand bits have to wait, so the time to finish follows the longest carry run in the actual operands. A completion detector watches the sum and carry-out codes. A four-state phase machine turns that into the acknowledge. `PH_IDLE` means all outputs are empty. `PH_FILL` means some outputs are valid. `PH_FULL` means all outputs are valid and the acknowledge is high. `PH_DRAIN` means the outputs are returning to empty while the acknowledge stays high.

The phase machine moves as follows:
- `PH_IDLE` goes to `PH_FULL` when every output is valid, and to `PH_FILL` when some are.
- `PH_FILL` goes to `PH_FULL` once every output is valid.
- `PH_FULL` goes to `PH_IDLE` when every output is empty, and to `PH_DRAIN` when only some are.
- `PH_DRAIN` goes to `PH_IDLE` once every output is empty.

Top module: `dr_ripple_adder`

## Requirements
- R1: Each dual-rail pair is ordered (true, false). (0,0) means empty, (1,0) means logic 1 and (0,1) means logic 0. (1,1) is illegal and never appears on an input or an output.
- R2: While ack is high, the true rails {cout_t, sum_t} equal a + b + cin as an integer. The false rails are their bitwise complement.
- R3: ack rises exactly one cycle after the first cycle in which every sum bit and the carry-out are valid. ack is never high before that.
- R4: ack falls exactly one cycle after the first cycle in which every sum bit and the carry-out are empty.
- R5: A slice whose operand bits are equal resolves its carry one cycle after its operands are valid, whatever its incoming carry is. With all-zero or all-one operands, ack rises 2 cycles after the inputs are applied.
- R6: Let t be 0 for the carry-in. Scanning slices from bit 0 upward, a slice with equal operand bits resolves at time 1, and a slice with differing operand bits resolves at (time of the slice below) + 1. ack rises at (maximum slice time) + 1 cycles. Alternating operands take W + 1 cycles.
- R7: The outputs are never all valid unless every input is valid. With the operands valid and the carry-in empty, ack stays low and sum bit 0 stays empty.
- R8: The outputs never become all empty while any input is still valid. With the operands empty and the carry-in still valid, ack stays high. After the last input becomes empty, ack falls W + 1 cycles later.
- R9: During reset, ack is low and every output is empty while the inputs are empty.
- R10: A valid output bit never shows the value opposite to the final result during a computation. Within one valid phase, it changes only by returning to empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; each edge advances carries by one slice |
| rst_n | input | 1 | Active-low synchronous reset |
| a_t | input | W | Operand A, true rails |
| a_f | input | W | Operand A, false rails |
| b_t | input | W | Operand B, true rails |
| b_f | input | W | Operand B, false rails |
| cin_t | input | 1 | Carry-in, true rail |
| cin_f | input | 1 | Carry-in, false rail |
| sum_t | output | W | Sum, true rails |
| sum_f | output | W | Sum, false rails |
| cout_t | output | 1 | Carry-out, true rail |
| cout_f | output | 1 | Carry-out, false rail |
| ack | output | 1 | Completion / acknowledge |

## Verification
The assertions assume the sender follows the four-phase protocol:
- It never drives the illegal (1,1) code.
- It holds every input valid until ack rises.
- It keeps the inputs empty until ack falls.

The bench applies each operand set only after ack is low, and blanks the inputs only after ack is high. The partial-input cases (carry-in late, carry-in held while the operands empty) change one input group at a time and hold each stable across several cycles. The weak-indication rules are therefore exercised without breaking those assumptions.

// File: rtl/dr_add_pkg.sv
package dr_add_pkg;

    // Dual-rail pair: bit 1 is the true rail, bit 0 is the false rail.
    typedef logic [1:0] dr_t;

    localparam dr_t DR_EMPTY = 2'b00;
    localparam dr_t DR_ONE   = 2'b10;
    localparam dr_t DR_ZERO  = 2'b01;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_FILL,
        PH_FULL,
        PH_DRAIN
    } phase_e;

    function automatic logic dr_is_valid(input dr_t x);
        return x[1] ^ x[0];
    endfunction

    function automatic dr_t dr_from_bit(input logic v);
        return v ? DR_ONE : DR_ZERO;
    endfunction

endpackage

// File: rtl/dr_add_stage.sv
module dr_add_stage
    import dr_add_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  dr_t  op_a,
    input  dr_t  op_b,
    input  dr_t  c_in,
    output dr_t  c_out,
    output dr_t  s_out
);

    dr_t  carry_q;
    dr_t  carry_d;
    logic ops_ok;
    logic gen;
    logic kil;
    logic prop;
    logic c_ok;
    logic all_null;

    always_comb begin
        ops_ok   = dr_is_valid(op_a) && dr_is_valid(op_b);
        gen      = ops_ok && op_a[1] && op_b[1];
        kil      = ops_ok && op_a[0] && op_b[0];
        prop     = ops_ok && !gen && !kil;
        c_ok     = dr_is_valid(c_in);
        all_null = (op_a == DR_EMPTY) && (op_b == DR_EMPTY) && (c_in == DR_EMPTY);

        // Hysteresis: empty only once every input is empty, settle when
        // the code allows, otherwise keep the present value.
        carry_d = carry_q;
        if (all_null)
            carry_d = DR_EMPTY;
        else if (gen)
            carry_d = DR_ONE;
        else if (kil)
            carry_d = DR_ZERO;
        else if (prop && c_ok)
            carry_d = c_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            carry_q <= DR_EMPTY;
        else
            carry_q <= carry_d;
    end

    assign c_out = carry_q;
    assign s_out = (ops_ok && c_ok) ? dr_from_bit(prop ^ c_in[1]) : DR_EMPTY;

endmodule

// File: rtl/dr_add_detect.sv
module dr_add_detect
    import dr_add_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] s_t,
    input  logic [W-1:0] s_f,
    input  dr_t          co,
    output logic         all_valid,
    output logic         all_empty
);

    assign all_valid = (&(s_t ^ s_f)) && dr_is_valid(co);
    assign all_empty = (~|(s_t | s_f)) && (co == DR_EMPTY);

endmodule

// File: rtl/dr_add_ctrl.sv
module dr_add_ctrl
    import dr_add_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic all_valid,
    input  logic all_empty,
    output logic ack
);

    phase_e state_q;
    phase_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= PH_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE: begin
                if (all_valid)
                    state_d = PH_FULL;
                else if (!all_empty)
                    state_d = PH_FILL;
            end
            PH_FILL: begin
                if (all_valid)
                    state_d = PH_FULL;
            end
            PH_FULL: begin
                if (all_empty)
                    state_d = PH_IDLE;
                else if (!all_valid)
                    state_d = PH_DRAIN;
            end
            PH_DRAIN: begin
                if (all_empty)
                    state_d = PH_IDLE;
            end
            default: state_d = PH_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            PH_FULL, PH_DRAIN: ack = 1'b1;
            default:           ack = 1'b0;
        endcase
    end

endmodule

// File: rtl/dr_ripple_adder.sv
module dr_ripple_adder
    import dr_add_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_t,
    input  logic [W-1:0] a_f,
    input  logic [W-1:0] b_t,
    input  logic [W-1:0] b_f,
    input  logic         cin_t,
    input  logic         cin_f,
    output logic [W-1:0] sum_t,
    output logic [W-1:0] sum_f,
    output logic         cout_t,
    output logic         cout_f,
    output logic         ack
);

    dr_t  chain [W+1];
    dr_t  sums  [W];
    logic all_valid;
    logic all_empty;

    assign chain[0] = {cin_t, cin_f};

    for (genvar i = 0; i < W; i++) begin : g_slice
        dr_add_stage u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .op_a  ({a_t[i], a_f[i]}),
            .op_b  ({b_t[i], b_f[i]}),
            .c_in  (chain[i]),
            .c_out (chain[i+1]),
            .s_out (sums[i])
        );
        assign sum_t[i] = sums[i][1];
        assign sum_f[i] = sums[i][0];
    end

    assign cout_t = chain[W][1];
    assign cout_f = chain[W][0];

    dr_add_detect #(.W(W)) u_detect (
        .s_t       (sum_t),
        .s_f       (sum_f),
        .co        (chain[W]),
        .all_valid (all_valid),
        .all_empty (all_empty)
    );

    dr_add_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .all_valid (all_valid),
        .all_empty (all_empty),
        .ack       (ack)
    );

endmodule

// File: rtl/dr_ripple_adder_chk.sv
module dr_ripple_adder_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] a_t,
    input logic [W-1:0] a_f,
    input logic [W-1:0] b_t,
    input logic [W-1:0] b_f,
    input logic         cin_t,
    input logic         cin_f,
    input logic [W-1:0] sum_t,
    input logic [W-1:0] sum_f,
    input logic         cout_t,
    input logic         cout_f,
    input logic         ack
);

    logic out_all_valid;
    logic out_all_empty;
    logic in_all_valid;
    logic in_all_empty;
    logic cout_ok;

    assign out_all_valid = (&(sum_t ^ sum_f)) && (cout_t ^ cout_f);
    assign out_all_empty = (~|(sum_t | sum_f)) && !cout_t && !cout_f;
    assign in_all_valid  = (&(a_t ^ a_f)) && (&(b_t ^ b_f)) && (cin_t ^ cin_f);
    assign in_all_empty  = (~|(a_t | a_f | b_t | b_f)) && !cin_t && !cin_f;
    assign cout_ok       = cout_t ^ cout_f;

    // R1: illegal code on inputs and outputs
    p_no_illegal_in_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((a_t & a_f) == '0) && ((b_t & b_f) == '0) && !(cin_t && cin_f));
    p_no_illegal_out_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((sum_t & sum_f) == '0) && !(cout_t && cout_f));

    // R3: acknowledge rises only after a cycle of all-valid outputs
    p_ack_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> $past(out_all_valid));

    // R4: acknowledge falls only after a cycle of all-empty outputs
    p_ack_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack) |-> $past(out_all_empty));

    // R7: weak condition on the valid side
    p_weak_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_all_valid |-> in_all_valid);

    // R8: weak condition on the empty side
    p_weak_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_all_empty) |-> in_all_empty);

    // R10: a valid carry-out never flips straight to the other value
    p_cout_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cout_ok && $past(cout_ok)) |-> (cout_t == $past(cout_t)));

    // R2: result stays put while acknowledged and inputs are stable
    p_hold_while_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && $past(ack) && $stable(a_t) && $stable(b_t) && $stable(cin_t) && in_all_valid)
        |-> ($stable(sum_t) && $stable(cout_t)));

endmodule

bind dr_ripple_adder dr_ripple_adder_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .a_t    (a_t),
    .a_f    (a_f),
    .b_t    (b_t),
    .b_f    (b_f),
    .cin_t  (cin_t),
    .cin_f  (cin_f),
    .sum_t  (sum_t),
    .sum_f  (sum_f),
    .cout_t (cout_t),
    .cout_f (cout_f),
    .ack    (ack)
);

// File: tb/tb_dr_ripple_adder.sv
module tb_dr_ripple_adder;

    localparam int  W          = 8;
    localparam time CLK_PERIOD = 10;
    localparam int  WAIT_MAX   = 4 * W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_t, a_f, b_t, b_f;
    logic         cin_t, cin_f;
    logic [W-1:0] sum_t, sum_f;
    logic         cout_t, cout_f;
    logic         ack;

    int errors = 0;
    int checks = 0;
    int cyc    = 0;

    dr_ripple_adder #(.W(W)) dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_t    (a_t),
        .a_f    (a_f),
        .b_t    (b_t),
        .b_f    (b_f),
        .cin_t  (cin_t),
        .cin_f  (cin_f),
        .sum_t  (sum_t),
        .sum_f  (sum_f),
        .cout_t (cout_t),
        .cout_f (cout_f),
        .ack    (ack)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
            report();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_lat(input logic [W-1:0] a, input logic [W-1:0] b);
        int tc = 0;
        int tmax = 0;
        int e;
        for (int j = 0; j < W; j++) begin
            if (a[j] == b[j]) e = 1;
            else              e = tc + 1;
            tc = e;
            if (e > tmax) tmax = e;
        end
        return tmax + 1;
    endfunction

    function automatic bit outs_valid();
        return (&(sum_t ^ sum_f)) && (cout_t ^ cout_f);
    endfunction

    function automatic bit outs_empty();
        return (~|(sum_t | sum_f)) && !cout_t && !cout_f;
    endfunction

    task automatic put_ab(input logic [W-1:0] a, input logic [W-1:0] b);
        a_t = a; a_f = ~a; b_t = b; b_f = ~b;
    endtask

    task automatic blank_ab();
        a_t = '0; a_f = '0; b_t = '0; b_f = '0;
    endtask

    task automatic put_c(input logic c);
        cin_t = c; cin_f = ~c;
    endtask

    task automatic blank_c();
        cin_t = 1'b0; cin_f = 1'b0;
    endtask

    task automatic check_result(input logic [W:0] expv, input string what);
        chk({cout_t, sum_t} == expv && {cout_f, sum_f} == ~expv, "R2", what,
            {cout_t, sum_t}, expv);
    endtask

    task automatic drain_full(input string what);
        int  k = 0;
        bit  prev_empty = 0;
        @(negedge clk);
        blank_ab();
        blank_c();
        do begin
            prev_empty = outs_empty();
            @(negedge clk);
            k++;
        end while (ack && k < WAIT_MAX);
        chk(k == W + 1, "R8", {what, " drain latency"}, k, W + 1);
        chk(prev_empty && outs_empty(), "R4", {what, " empty before ack falls"},
            {cout_t, sum_t}, 0);
    endtask

    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic c, input string lat_req, input string what);
        logic [W:0] expv;
        int  lat;
        int  k = 0;
        bit  clean = 1;
        bit  legal = 1;
        bit  prev_valid = 0;
        expv = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
        lat  = exp_lat(a, b);
        @(negedge clk);
        put_ab(a, b);
        put_c(c);
        do begin
            prev_valid = outs_valid();
            @(negedge clk);
            k++;
            if ((sum_t & ~expv[W-1:0]) != '0 || (sum_f & expv[W-1:0]) != '0 ||
                (cout_t && !expv[W]) || (cout_f && expv[W]))
                clean = 0;
            if ((sum_t & sum_f) != '0 || (cout_t && cout_f))
                legal = 0;
        end while (!ack && k < WAIT_MAX);
        chk(k == lat, lat_req, {what, " completion cycles"}, k, lat);
        chk(prev_valid, "R3", {what, " outputs valid before ack"}, prev_valid, 1);
        chk(clean, "R10", {what, " no wrong valid value"}, clean, 1);
        chk(legal, "R1", {what, " no illegal code"}, legal, 1);
        check_result(expv, what);
        drain_full(what);
    endtask

    initial begin
        logic [W-1:0] ra, rb;
        logic         rc;
        int           k;
        void'($urandom(32'd1234));
        blank_ab();
        blank_c();
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(!ack, "R9", "ack in reset", ack, 0);
        chk(outs_empty(), "R9", "outputs in reset", {cout_t, sum_t}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!ack && outs_empty(), "R9", "idle after reset", ack, 0);

        // R5: equal operand bits settle in one step
        run_op('0, '0, 1'b0, "R5", "all zero");
        run_op('1, '1, 1'b1, "R5", "all one");
        run_op('0, '0, 1'b1, "R5", "zero with carry in");
        // R6: longest propagate chains
        run_op({(W/2){2'b01}}, {(W/2){2'b10}}, 1'b1, "R6", "alternating");
        run_op('1, '0, 1'b1, "R6", "ripple from carry in");
        run_op({1'b1, {(W-1){1'b0}}} | 1, {(W-1){1'b1}} & ~1, 1'b0, "R6", "chain from bit 0");

        // R7: operands valid, carry-in late
        @(negedge clk);
        put_ab(8'h0F, 8'h01);
        repeat (W + 3) @(negedge clk);
        chk(!ack, "R7", "ack with carry-in empty", ack, 0);
        chk(!sum_t[0] && !sum_f[0], "R7", "sum bit 0 empty", {sum_t[0], sum_f[0]}, 0);
        put_c(1'b1);
        k = 0;
        do begin @(negedge clk); k++; end while (!ack && k < WAIT_MAX);
        chk(ack, "R7", "ack after carry-in arrives", ack, 1);
        check_result(9'h011, "late carry");

        // R8: carry-in held valid while operands empty
        @(negedge clk);
        blank_ab();
        repeat (W + 3) @(negedge clk);
        chk(ack, "R8", "ack held with carry-in valid", ack, 1);
        chk(cout_t ^ cout_f, "R8", "cout held valid", {cout_t, cout_f}, 2'b01);
        put_c(1'b0);
        blank_c();
        k = 0;
        do begin @(negedge clk); k++; end while (ack && k < WAIT_MAX);
        chk(k == W + 1, "R8", "drain after carry-in empties", k, W + 1);
        chk(outs_empty(), "R4", "outputs empty after late drain", {cout_t, sum_t}, 0);

        // R6: random operands
        for (int n = 0; n < 40; n++) begin
            ra = W'($urandom);
            rb = W'($urandom);
            rc = 1'($urandom);
            run_op(ra, rb, rc, "R6", "random");
        end

        report();
        $finish;
    end

endmodule